// File: doc/BRIEF.md
# Jitter Compensation Datapath

This block is a streaming fixed-point stage that removes the error caused by sampling-clock jitter from a stream of converter samples. Each accepted sample enters a nine-sample window. An anti-symmetric derivative filter works on that window. It forms the difference of each mirrored sample pair and multiplies it by one of four coefficients, so the centre tap costs nothing.

A separate raw jitter estimate arrives with each sample. A leaky accumulator smooths it, and the leak is set by a power-of-two shift. The output is a first-order correction: the window's centre sample minus the product of the smoothed jitter estimate and the derivative. The centre sample is four accepted samples old, which matches the group delay of the derivative filter.

The stream is qualified by a valid flag. Idle cycles freeze all history, and the output valid follows the input valid with a fixed latency.

Top module: `jitcomp_top`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_sample is 0. The sample window and the smoothed estimate also clear to 0.
- R2: out_valid equals in_valid delayed by exactly 3 clock cycles.
- R3: A cycle with in_valid low advances neither the sample window nor the smoothed jitter estimate. The output sequence depends only on the accepted samples.
- R4: The derivative is d = sat(floor(S / 2^11)), where S is the sum over i = 1..4 of C_i * (w[4-i] - w[4+i]). Here w[0] is the newest accepted sample. The default coefficients are C1 = 1638, C2 = -410, C3 = 78 and C4 = -7, as signed 12-bit values.
- R5: When the smoothed estimate is 0, each output equals the sample accepted four accepted samples earlier, w[4].
- R6: The smoothed estimate a starts at 0. On every accepted sample it becomes sat(a + floor((j - a) / 2^6)), where j is the raw estimate delivered with that sample.
- R7: For each accepted sample, the output is sat(w[4] - floor(a * d / 2^15)). It uses the window and smoothed estimate as updated by that sample, with a and d read as signed Q15 values.
- R8: Every saturation clamps to the signed 16-bit range [-32768, 32767].
- R9: out_sample changes only on cycles where out_valid is high, and holds its last value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_sample and in_jit |
| in_sample | input | 16 | Signed converter sample |
| in_jit | input | 16 | Signed raw jitter estimate, Q15 |
| out_valid | output | 1 | Qualifies out_sample |
| out_sample | output | 16 | Signed corrected sample |

## Verification
The bench inserts idle cycles between accepted samples. A design that shifted its window or leaked its accumulator on every clock would then produce outputs that drift away from the model. A zero-estimate ramp checks the four-sample alignment of the centre tap, so an off-by-one delay shows up as a constant offset equal to the ramp slope. Alternating full-scale samples combined with a near-negative-full-scale estimate push both the derivative and the final subtraction into saturation. Without saturation there, the output would wrap to the opposite sign. Random streams with random gaps cover rounding: a truncation toward zero instead of a floor appears as one-LSB errors on negative products.

// File: rtl/jc_pkg.sv
package jc_pkg;

    localparam int WIDE_W = 48;

    // Clamp a wide signed value to a signed range of w bits.
    function automatic logic signed [WIDE_W-1:0] clamp(input logic signed [WIDE_W-1:0] v,
                                                       input int w);
        logic signed [WIDE_W-1:0] hi;
        logic signed [WIDE_W-1:0] lo;
        hi = (48'sd1 <<< (w - 1)) - 48'sd1;
        lo = -(48'sd1 <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/jc_deriv_fir.sv
module jc_deriv_fir #(
    parameter int DW   = 16,
    parameter int CW   = 12,
    parameter int HALF = 4,
    parameter logic [HALF*CW-1:0] COEFS = {12'(-7), 12'(78), 12'(-410), 12'(1638)}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    output logic                 out_vb,
    output logic signed [DW-1:0] out_deriv,
    output logic signed [DW-1:0] out_centre
);
    import jc_pkg::*;

    localparam int NT = 2 * HALF + 1;
    localparam int PW = DW + 1 + CW;
    localparam int SW = PW + $clog2(HALF) + 1;

    typedef struct packed {
        logic [NT-1:0][DW-1:0] win;
        logic                  va;
        logic                  vb;
        logic signed [DW-1:0]  deriv;
        logic signed [DW-1:0]  centre;
    } fir_st_t;

    fir_st_t s_q, s_d;

    always_comb begin
        logic signed [SW-1:0]     sum;
        logic signed [DW:0]       dif;
        logic signed [PW-1:0]     prod;
        logic signed [WIDE_W-1:0] t;
        s_d = s_q;
        if (in_valid) s_d.win = {s_q.win[NT-2:0], in_sample};
        s_d.va = in_valid;
        sum = '0;
        for (int i = 1; i <= HALF; i++) begin
            dif  = $signed({s_q.win[HALF-i][DW-1], s_q.win[HALF-i]})
                 - $signed({s_q.win[HALF+i][DW-1], s_q.win[HALF+i]});
            prod = PW'(dif) * PW'($signed(COEFS[(i-1)*CW +: CW]));
            sum  = sum + SW'(prod);
        end
        t = clamp(WIDE_W'(sum >>> (CW - 1)), DW);
        if (s_q.va) begin
            s_d.deriv  = t[DW-1:0];
            s_d.centre = s_q.win[HALF];
        end
        s_d.vb = s_q.va;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_vb     = s_q.vb;
    assign out_deriv  = s_q.deriv;
    assign out_centre = s_q.centre;
endmodule

// File: rtl/jc_leaky_lpf.sv
module jc_leaky_lpf #(
    parameter int DW = 16,
    parameter int K  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_jit,
    output logic signed [DW-1:0] acc_o,
    output logic signed [DW-1:0] jsm_o
);
    import jc_pkg::*;

    typedef struct packed {
        logic signed [DW-1:0] acc;
        logic                 va;
        logic signed [DW-1:0] jsm;
    } lpf_st_t;

    lpf_st_t s_q, s_d;

    always_comb begin
        logic signed [DW:0]       diff;
        logic signed [DW:0]       step;
        logic signed [WIDE_W-1:0] t;
        s_d  = s_q;
        diff = $signed({in_jit[DW-1], in_jit}) - $signed({s_q.acc[DW-1], s_q.acc});
        step = diff >>> K;
        t    = clamp(WIDE_W'(s_q.acc) + WIDE_W'(step), DW);
        if (in_valid) s_d.acc = t[DW-1:0];
        s_d.va = in_valid;
        if (s_q.va) s_d.jsm = s_q.acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_o = s_q.acc;
    assign jsm_o = s_q.jsm;
endmodule

// File: rtl/jc_correct.sv
module jc_correct #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vb,
    input  logic signed [DW-1:0] in_deriv,
    input  logic signed [DW-1:0] in_centre,
    input  logic signed [DW-1:0] in_jsm,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sample
);
    import jc_pkg::*;

    localparam int MW = 2 * DW;

    typedef struct packed {
        logic                 ov;
        logic signed [DW-1:0] os;
    } cor_st_t;

    cor_st_t s_q, s_d;

    always_comb begin
        logic signed [MW-1:0]     prod;
        logic signed [WIDE_W-1:0] t;
        s_d  = s_q;
        prod = MW'(in_jsm) * MW'(in_deriv);
        t    = clamp(WIDE_W'(in_centre) - WIDE_W'(prod >>> (DW - 1)), DW);
        if (in_vb) s_d.os = t[DW-1:0];
        s_d.ov = in_vb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid  = s_q.ov;
    assign out_sample = s_q.os;
endmodule

// File: rtl/jitcomp_top.sv
module jitcomp_top #(
    parameter int DW     = 16,
    parameter int CW     = 12,
    parameter int HALF   = 4,
    parameter int LEAK_K = 6,
    parameter logic [HALF*CW-1:0] COEFS = {12'(-7), 12'(78), 12'(-410), 12'(1638)}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_sample,
    input  logic signed [DW-1:0] in_jit,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_sample
);
    logic                 fir_vb;
    logic signed [DW-1:0] fir_deriv;
    logic signed [DW-1:0] fir_centre;
    logic signed [DW-1:0] lpf_acc;
    logic signed [DW-1:0] lpf_jsm;

    jc_deriv_fir #(.DW(DW), .CW(CW), .HALF(HALF), .COEFS(COEFS)) fir_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_vb(fir_vb), .out_deriv(fir_deriv), .out_centre(fir_centre)
    );

    jc_leaky_lpf #(.DW(DW), .K(LEAK_K)) lpf_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_jit(in_jit),
        .acc_o(lpf_acc), .jsm_o(lpf_jsm)
    );

    jc_correct #(.DW(DW)) cor_i (
        .clk(clk), .rst_n(rst_n), .in_vb(fir_vb), .in_deriv(fir_deriv),
        .in_centre(fir_centre), .in_jsm(lpf_jsm),
        .out_valid(out_valid), .out_sample(out_sample)
    );
endmodule

// File: rtl/jitcomp_top_chk.sv
module jitcomp_top_chk #(
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_sample,
    input logic signed [DW-1:0] lpf_acc
);
    logic [1:0] cyc;
    logic [2:0] vh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc <= '0;
            vh  <= '0;
        end else begin
            if (cyc != 2'd3) cyc <= cyc + 2'd1;
            vh <= {vh[1:0], in_valid};
        end
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_state_chk: assert (!out_valid && out_sample == '0);
        end
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd3) |-> (out_valid == vh[2]));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc != 2'd0 && !out_valid) |-> $stable(out_sample));

    // R3
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(lpf_acc));
endmodule

bind jitcomp_top jitcomp_top_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_sample(out_sample), .lpf_acc(lpf_acc)
);

// File: tb/jitcomp_top_tb_top.sv
module jitcomp_top_tb_top;
    logic               clk = 1'b0;
    logic               rst_n;
    logic               in_valid;
    logic signed [15:0] in_sample;
    logic signed [15:0] in_jit;
    logic               out_valid;
    logic signed [15:0] out_sample;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    typedef struct { bit v; longint val; string tag; } exp_t;
    exp_t   q[$];
    longint w[9];
    longint a;
    longint last;
    int     cf[4] = '{1638, -410, 78, -7};

    always #5 clk = ~clk;

    jitcomp_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_jit(in_jit), .out_valid(out_valid), .out_sample(out_sample)
    );

    function automatic longint bsat(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: compare outputs, drive inputs, advance the model.
    task automatic step(bit v, longint smp, longint jit, string tag);
        exp_t e;
        exp_t n;
        longint d;
        e = q.pop_front();
        chk(out_valid == e.v, "R2", longint'(out_valid), longint'(e.v));
        chk(longint'(out_sample) == e.val, e.v ? e.tag : "R9", longint'(out_sample), e.val);
        in_valid  = v;
        in_sample = 16'(smp);
        in_jit    = 16'(jit);
        if (v) begin
            for (int i = 8; i > 0; i--) w[i] = w[i-1];
            w[0] = longint'(in_sample);
            a = bsat(a + ((longint'(in_jit) - a) >>> 6));
            d = 0;
            for (int i = 1; i <= 4; i++) d += cf[i-1] * (w[4-i] - w[4+i]);
            d = bsat(d >>> 11);
            last = bsat(w[4] - ((a * d) >>> 15));
        end
        n.v = v; n.val = last; n.tag = tag;
        q.push_back(n);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        exp_t z;
        rst_n = 0; in_valid = 0; in_sample = 0; in_jit = 0;
        a = 0; last = 0;
        for (int i = 0; i < 9; i++) w[i] = 0;
        z.v = 0; z.val = 0; z.tag = "R1";
        repeat (3) q.push_back(z);
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
            chk(out_sample == 16'sd0, "R1", longint'(out_sample), 0);
        end
        rst_n = 1;
        // zero estimate: output is the delayed sample
        for (int k = 0; k < 40; k++) step(1, k * 300 - 6000, 0, "R5");
        // idle gaps must freeze history
        for (int k = 0; k < 40; k++) step(k % 3 != 0, k * 517 - 10000, 12000, "R3");
        // estimate step response of the leaky accumulator
        for (int k = 0; k < 60; k++)
            step(1, (k % 10 < 5) ? k * 400 : -k * 300, (k < 30) ? 20000 : -20000, "R6");
        // sawtooth with a strong estimate exercises the derivative taps
        for (int k = 0; k < 40; k++) step(1, (k % 16) * 1500 - 12000, 16384, "R4");
        // full-scale alternation drives both saturations
        for (int k = 0; k < 200; k++)
            step(1, (k % 4 < 2) ? 32767 : -32768, -32768, "R8");
        // random stream with random gaps
        for (int k = 0; k < 300; k++)
            step(($urandom % 4) != 0, longint'($signed(16'($urandom))),
                 longint'($signed(16'($urandom))), "R7");
        for (int k = 0; k < 6; k++) step(0, 0, 0, "R2");
        finish_run();
    end
endmodule